// File: doc/BRIEF.md
# Up/Down Period Timer Counter

A parameterised (16-bit by default) timer/counter that moves one step on each qualified tick. Counting up, it climbs to a programmable period value (TOP), holds it for one tick, then clears to zero. Counting down, it steps to zero (BOTTOM), holds it for one tick, then reloads from the period register. On every qualified tick the block takes exactly one action: clear, reload, increment or decrement. A one-cycle `wrap_pulse` marks each clear-on-wrap and each reload. That pulse can be fed into the tick input of a second instance, so two instances form a 32-bit counter.

Software reaches the block through a single write port. `wr_sel` picks the target: 0 = counter value, 1 = period, 2 = control. The control word uses these bits: bit 0 = run, bit 1 = count down, bits 3:2 = event mode. The event modes are: 00 = event ignored, 01 = `evt_in` level sets the direction (1 = down), 10 = `evt_in` replaces `tick_en` as the tick, 11 = event ignored. A write to the counter beats any action in the same cycle. A write to the period or control register governs every tick from the next cycle on.

A four-state machine holds the run and direction status. The states are HALT_UP, HALT_DOWN, RUN_UP and RUN_DOWN. There are two kinds of transition:
- CTRL_WRITE goes to the state given by the run and down bits of the written control word.
- EVENT_STEER applies in event mode 01 when there is no control write. It moves between the UP and DOWN variants of the current run/halt status according to the sampled `evt_in`.

Otherwise the state holds (HOLD). `dir_out` is high in the DOWN states.

Top module: `updown_period_timer`

## Requirements
- R1: After reset the counter is 0, the period is all-ones, the direction is up (`dir_out`=0), the block is halted, and `wrap_pulse` is 0.
- R2: While running up, each tick adds one to the counter. A cycle without a tick leaves the counter unchanged.
- R3: While running up, a tick with the counter equal to TOP sets the counter to 0 and raises `wrap_pulse` for exactly one cycle.
- R4: While running down, each tick subtracts one. A tick at 0 loads the period value and raises `wrap_pulse` for one cycle.
- R5: A counter write (`wr_sel`=0) sets the counter to `wr_data` at the next edge. It overrides any tick action in that cycle, and no pulse is raised.
- R6: A control write changes the direction. A tick in the same cycle still uses the old direction, and the next tick uses the new one.
- R7: A period write (`wr_sel`=1) becomes TOP and reload value with no buffering, for every tick from the next cycle.
- R8: In event mode 01, `evt_in` is sampled each cycle: 1 selects down and 0 selects up. The new direction applies to ticks from the following cycle.
- R9: In event mode 10, `evt_in` is the tick and `tick_en` is ignored.
- R10: A counter above TOP while counting up keeps counting to all-ones, then clears to 0 with a pulse.
- R11: While halted (run bit 0), ticks leave the counter unchanged and raise no pulse.
- R12: With one instance's `wrap_pulse` driving a second instance's `tick_en`, the pair counts as one 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count tick (unless event mode 10) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 counter, 1 period, 2 control |
| wr_data | input | WIDTH | Write data |
| evt_in | input | 1 | Event input (direction or tick) |
| cnt_out | output | WIDTH | Counter value |
| wrap_pulse | output | 1 | One-cycle overflow/underflow pulse |
| dir_out | output | 1 | Current direction, 1 = down |

## Verification
A wrong state in the controller appears on `dir_out` in the cycle after the faulty transition. It appears on `cnt_out` at the first tick after that, as a step of the wrong sign or a step where a hold was due. A wrong action choice at TOP or BOTTOM appears one edge later as a counter value other than 0 or the period, together with a missing or misplaced `wrap_pulse`. These are checked at the exact cycle, so every fault is seen within one clock of the tick that exposes it.

// File: rtl/utc_pkg.sv
package utc_pkg;

    typedef enum logic [1:0] {
        ST_HALT_UP   = 2'd0,
        ST_HALT_DOWN = 2'd1,
        ST_RUN_UP    = 2'd2,
        ST_RUN_DOWN  = 2'd3
    } utc_state_e;

    typedef enum logic [1:0] {
        EVM_OFF  = 2'd0,
        EVM_DIR  = 2'd1,
        EVM_TICK = 2'd2,
        EVM_RSVD = 2'd3
    } utc_evmode_e;

    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_INC    = 3'd1,
        ACT_DEC    = 3'd2,
        ACT_CLEAR  = 3'd3,
        ACT_RELOAD = 3'd4,
        ACT_LOAD   = 3'd5
    } utc_act_e;

    localparam logic [1:0] SEL_COUNT  = 2'd0;
    localparam logic [1:0] SEL_PERIOD = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_DOWN_BIT = 1;
    localparam int CTRL_EVM_LSB  = 2;

endpackage

// File: rtl/utc_ctrl_fsm.sv
module utc_ctrl_fsm
    import utc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        ctrl_run,
    input  logic        ctrl_down,
    input  logic [1:0]  ctrl_evmode,
    input  logic        evt_in,
    output utc_state_e  state_q,
    output utc_evmode_e evmode_q
);

    utc_state_e state_d;
    logic       run_now;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HALT_UP;
            evmode_q <= EVM_OFF;
        end else begin
            state_q <= state_d;
            if (ctrl_wr) begin
                evmode_q <= utc_evmode_e'(ctrl_evmode);
            end
        end
    end

    // Next-state logic: CTRL_WRITE > EVENT_STEER > HOLD
    always_comb begin
        unique case (state_q)
            ST_HALT_UP, ST_HALT_DOWN: run_now = 1'b0;
            ST_RUN_UP,  ST_RUN_DOWN:  run_now = 1'b1;
            default:                  run_now = 1'b0;
        endcase

        state_d = state_q;
        if (ctrl_wr) begin
            state_d = utc_state_e'({ctrl_run, ctrl_down});
        end else if (evmode_q == EVM_DIR) begin
            state_d = utc_state_e'({run_now, evt_in});
        end
    end

endmodule

// File: rtl/utc_step.sv
module utc_step
    import utc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  utc_state_e       state_q,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [WIDTH-1:0] cnt_q,
    input  logic [WIDTH-1:0] top_q,
    output utc_act_e         act
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] BOTTOM   = '0;

    always_comb begin
        act = ACT_HOLD;
        unique case (state_q)
            ST_HALT_UP, ST_HALT_DOWN: act = ACT_HOLD;
            ST_RUN_UP: begin
                if (tick) begin
                    act = ((cnt_q == top_q) || (cnt_q == ALL_ONES)) ? ACT_CLEAR : ACT_INC;
                end
            end
            ST_RUN_DOWN: begin
                if (tick) begin
                    act = (cnt_q == BOTTOM) ? ACT_RELOAD : ACT_DEC;
                end
            end
            default: act = ACT_HOLD;
        endcase
        if (cnt_wr) begin
            act = ACT_LOAD;
        end
    end

endmodule

// File: rtl/utc_datapath.sv
module utc_datapath
    import utc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  utc_act_e         act,
    input  logic             per_wr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] cnt_q,
    output logic [WIDTH-1:0] per_q,
    output logic             pulse_q
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            per_q   <= '1;
            pulse_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_HOLD:   cnt_q <= cnt_q;
                ACT_INC:    cnt_q <= cnt_q + ONE;
                ACT_DEC:    cnt_q <= cnt_q - ONE;
                ACT_CLEAR:  cnt_q <= '0;
                ACT_RELOAD: cnt_q <= per_q;
                ACT_LOAD:   cnt_q <= wr_data;
                default:    cnt_q <= cnt_q;
            endcase
            pulse_q <= (act == ACT_CLEAR) || (act == ACT_RELOAD);
            if (per_wr) begin
                per_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/updown_period_timer.sv
module updown_period_timer
    import utc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             evt_in,
    output logic [WIDTH-1:0] cnt_out,
    output logic             wrap_pulse,
    output logic             dir_out
);

    utc_state_e       state_q;
    utc_evmode_e      evmode_q;
    utc_act_e         act;
    logic             cnt_wr, per_wr, ctrl_wr;
    logic             tick_now, running;
    logic [WIDTH-1:0] period_q;

    assign cnt_wr  = wr_en && (wr_sel == SEL_COUNT);
    assign per_wr  = wr_en && (wr_sel == SEL_PERIOD);
    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

    assign tick_now = (evmode_q == EVM_TICK) ? evt_in : tick_en;

    // Output decode of the state
    always_comb begin
        unique case (state_q)
            ST_HALT_UP:   begin running = 1'b0; dir_out = 1'b0; end
            ST_HALT_DOWN: begin running = 1'b0; dir_out = 1'b1; end
            ST_RUN_UP:    begin running = 1'b1; dir_out = 1'b0; end
            ST_RUN_DOWN:  begin running = 1'b1; dir_out = 1'b1; end
            default:      begin running = 1'b0; dir_out = 1'b0; end
        endcase
    end

    utc_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_run    (wr_data[CTRL_RUN_BIT]),
        .ctrl_down   (wr_data[CTRL_DOWN_BIT]),
        .ctrl_evmode (wr_data[CTRL_EVM_LSB +: 2]),
        .evt_in      (evt_in),
        .state_q     (state_q),
        .evmode_q    (evmode_q)
    );

    utc_step #(.WIDTH(WIDTH)) u_step (
        .state_q (state_q),
        .tick    (tick_now),
        .cnt_wr  (cnt_wr),
        .cnt_q   (cnt_out),
        .top_q   (period_q),
        .act     (act)
    );

    utc_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .per_wr  (per_wr),
        .wr_data (wr_data),
        .cnt_q   (cnt_out),
        .per_q   (period_q),
        .pulse_q (wrap_pulse)
    );

endmodule

// File: rtl/utc_checker.sv
module utc_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic [WIDTH-1:0] wr_data,
    input logic [WIDTH-1:0] cnt_out,
    input logic [WIDTH-1:0] period_q,
    input logic             wrap_pulse,
    input logic             dir_out,
    input logic             running,
    input logic             tick_now
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    p_cnt_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_out == $past(wr_data)) && !wrap_pulse);

    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && running && !dir_out && tick_now &&
         cnt_out != period_q && cnt_out != ALL_ONES)
        |=> cnt_out == ($past(cnt_out) + WIDTH'(1)));

    p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && running && !dir_out && tick_now && cnt_out == period_q)
        |=> (cnt_out == '0) && wrap_pulse);

    p_down_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && running && dir_out && tick_now && cnt_out == '0)
        |=> (cnt_out == $past(period_q)) && wrap_pulse);

    p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !running) |=> $stable(cnt_out) && !wrap_pulse);

endmodule

bind updown_period_timer utc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_wr     (cnt_wr),
    .wr_data    (wr_data),
    .cnt_out    (cnt_out),
    .period_q   (period_q),
    .wrap_pulse (wrap_pulse),
    .dir_out    (dir_out),
    .running    (running),
    .tick_now   (tick_now)
);

// File: tb/updown_period_timer_test.sv
module updown_period_timer_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tick_en, wr_en, evt_in;
    logic [1:0]   wr_sel;
    logic [W-1:0] wr_data;
    logic [W-1:0] cnt_out;
    logic         wrap_pulse, dir_out;

    logic         hi_wr_en;
    logic [1:0]   hi_wr_sel;
    logic [W-1:0] hi_wr_data;
    logic [W-1:0] hi_cnt;
    logic         hi_pulse, hi_dir;

    int tests_run = 0;
    int tests_failed = 0;

    always #5 clk = ~clk;

    updown_period_timer #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .evt_in(evt_in),
        .cnt_out(cnt_out), .wrap_pulse(wrap_pulse), .dir_out(dir_out)
    );

    // upper half of a chained pair (R12)
    updown_period_timer #(.WIDTH(W)) uut_hi (
        .clk(clk), .rst_n(rst_n), .tick_en(wrap_pulse), .wr_en(hi_wr_en),
        .wr_sel(hi_wr_sel), .wr_data(hi_wr_data), .evt_in(1'b0),
        .cnt_out(hi_cnt), .wrap_pulse(hi_pulse), .dir_out(hi_dir)
    );

    typedef struct packed {
        logic         wr;
        logic [1:0]   sel;
        logic [15:0]  data;
        logic         tick;
        logic         evt;
        logic [15:0]  exp_cnt;
        logic         exp_pulse;
        logic         exp_dir;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 29;
    // sel: 0 counter, 1 period, 2 control (b0 run, b1 down, b3:2 event mode)
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd2, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd6},  // run up
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, 8'd2},  // R2
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0002, 1'b0, 1'b0, 8'd2},
        '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0002, 1'b0, 1'b0, 8'd2},  // R2 hold
        '{1'b1, 2'd1, 16'h0003, 1'b0, 1'b0, 16'h0002, 1'b0, 1'b0, 8'd7},  // R7 period 3
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0003, 1'b0, 1'b0, 8'd7},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 8'd3},  // R3 wrap
        '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd3},  // R3 pulse ends
        '{1'b1, 2'd2, 16'h0003, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b1, 8'd6},  // R6 old dir used
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 8'd6},  // R6 new dir
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0003, 1'b1, 1'b1, 8'd4},  // R4 reload
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0002, 1'b0, 1'b1, 8'd4},
        '{1'b1, 2'd0, 16'h000A, 1'b1, 1'b0, 16'h000A, 1'b0, 1'b1, 8'd5},  // R5 write wins
        '{1'b1, 2'd2, 16'h0001, 1'b0, 1'b0, 16'h000A, 1'b0, 1'b0, 8'd6},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h000B, 1'b0, 1'b0, 8'd10}, // R10 above TOP
        '{1'b1, 2'd0, 16'hFFFF, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0, 8'd5},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 8'd10}, // R10 wrap
        '{1'b1, 2'd2, 16'h0000, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, 8'd11}, // halt
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, 8'd11}, // R11 ignored
        '{1'b1, 2'd2, 16'h0005, 1'b0, 1'b1, 16'h0001, 1'b0, 1'b0, 8'd8},  // mode 01
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 16'h0002, 1'b0, 1'b1, 8'd8},  // R8
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 16'h0001, 1'b0, 1'b1, 8'd8},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd8},
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, 8'd8},
        '{1'b1, 2'd2, 16'h0009, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0, 8'd9},  // mode 10
        '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, 8'd9},  // R9 tick_en ignored
        '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 16'h0002, 1'b0, 1'b0, 8'd9},
        '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 16'h0003, 1'b0, 1'b0, 8'd9},
        '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 8'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [1:0] s, input logic [W-1:0] d,
                         input logic t, input logic e);
        @(negedge clk);
        wr_en = w; wr_sel = s; wr_data = d; tick_en = t; evt_in = e;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; tick_en = 0; wr_en = 0; wr_sel = 0; wr_data = 0; evt_in = 0;
        hi_wr_en = 0; hi_wr_sel = 0; hi_wr_data = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        check("R1 cnt", 32'(cnt_out), 32'h0);
        check("R1 pulse", 32'(wrap_pulse), 32'h0);
        check("R1 dir", 32'(dir_out), 32'h0);
        drive(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
        check("R1 halted after reset", 32'(cnt_out), 32'h0);
        // R1 period all-ones: FFFE -> FFFF -> 0
        drive(1'b1, 2'd0, 16'hFFFE, 1'b0, 1'b0);
        drive(1'b1, 2'd2, 16'h0001, 1'b0, 1'b0);
        drive(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
        check("R1 period reset top", 32'(cnt_out), 32'hFFFF);
        drive(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
        check("R1 period wrap", 32'({wrap_pulse, cnt_out}), 32'h10000);
        drive(1'b1, 2'd2, 16'h0000, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].wr, VEC[i].sel, VEC[i].data, VEC[i].tick, VEC[i].evt);
            check($sformatf("R%0d vec%0d", VEC[i].req, i),
                  32'({dir_out, wrap_pulse, cnt_out}),
                  32'({VEC[i].exp_dir, VEC[i].exp_pulse, VEC[i].exp_cnt}));
        end

        // R12 chained 32-bit count
        @(negedge clk);
        hi_wr_en = 1; hi_wr_sel = 2'd2; hi_wr_data = 16'h0001;
        wr_en = 1; wr_sel = 2'd2; wr_data = 16'h0001; tick_en = 0; evt_in = 0;
        @(negedge clk);
        hi_wr_sel = 2'd0; hi_wr_data = 16'h0000;
        wr_sel = 2'd0; wr_data = 16'hFFFE;
        @(negedge clk);
        hi_wr_en = 0;
        wr_sel = 2'd1; wr_data = 16'hFFFF;
        drive(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
        drive(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
        check("R12 low wrap", 32'({hi_cnt, cnt_out}), 32'h0000_0000);
        drive(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
        check("R12 carry", 32'({hi_cnt, cnt_out}), 32'h0001_0001);
        drive(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
        check("R12 next", 32'({hi_cnt, cnt_out}), 32'h0001_0002);

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R1 mid-run reset", 32'({dir_out, wrap_pulse, cnt_out}), 32'h0);
        drive(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
        check("R11 halted after reset", 32'(cnt_out), 32'h0);

        finish_run();
    end

endmodule